// File: doc/BRIEF.md
# CAN Transmit Message Buffer

This block holds exactly one outgoing CAN frame for a controller. Software programs it through a small word-addressed write port. It writes a frame-descriptor word (identifier format, remote flag, length code), a 29-bit identifier and two 32-bit payload words. It then sets a request bit in a command word. While the frame is outstanding the block reports itself busy and offers the frame to a downstream bit-stream engine on a valid/ready handshake. That engine serialises the frame, handles arbitration and reports the result back.

When the engine signals success, the buffer frees itself and pulses a one-cycle finish event. On lost arbitration it either offers the same frame again or drops it, depending on a retransmit enable in the mode word. A pending request can be withdrawn by clearing the request bit, but only until the engine has taken the frame.

Word addresses: 0 mode, 1 command, 2 frame descriptor, 3 identifier, 4 payload low, 5 payload high.

Top module: `cantx_msgbuf`

## Requirements
- R1: Writing a command word (address 1) with bit 0 set while the buffer is idle starts a request: on the next cycle `frm_valid` and `stat_buf_full` are 1.
- R2: Descriptor word (address 2) fields are presented as follows: bit 7 drives `frm_ext` (29-bit identifier), bit 6 drives `frm_rtr` (remote frame), and bits 3:0 drive `frm_dlc`.
- R3: Only bits 28:0 of an identifier write (address 3) are kept and presented on `frm_id`. Bits 31:29 have no effect.
- R4: Payload low (address 4) occupies `frm_data[31:0]` and payload high (address 5) occupies `frm_data[63:32]`. Byte 0 sits at `frm_data[7:0]` and byte 7 at `frm_data[63:56]`.
- R5: For a remote frame, `frm_dlc` and `frm_data` are presented as zero, whatever was written.
- R6: Bit 10 of the mode word (address 0) enables retransmission. With it set, lost arbitration re-offers the same frame. With it clear, the frame is dropped, the buffer goes idle and no finish event occurs.
- R7: Writes to addresses 2 to 5 while the buffer is busy are ignored, and the frame already held is the one presented.
- R8: Writing bit 0 clear to the command word while the frame is offered but not yet accepted cancels it. If the engine accepts in that same cycle, the acceptance wins. After acceptance, clearing the bit has no effect.
- R9: When the engine reports success, `stat_buf_full` and `stat_in_progress` fall and `tx_finish` is 1 for exactly one cycle.
- R10: `stat_in_progress` is 1 only from acceptance until success or lost arbitration. `stat_buf_full` is 1 from request until success, drop or cancel.
- R11: Once offered, `frm_valid` and the frame stay unchanged until the engine accepts it or it is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| stat_buf_full | output | 1 | Buffer holds a frame not yet finished |
| stat_in_progress | output | 1 | Engine has accepted the frame and is sending it |
| frm_valid | output | 1 | Frame offered to engine |
| frm_ready | input | 1 | Engine accepts offered frame |
| frm_ext | output | 1 | Extended identifier format |
| frm_rtr | output | 1 | Remote frame |
| frm_dlc | output | 4 | Data length code (zero for remote) |
| frm_id | output | 29 | Identifier |
| frm_data | output | 64 | Payload, byte 0 in bits 7:0 |
| eng_done | input | 1 | Engine reports successful transmission |
| eng_arb_lost | input | 1 | Engine reports lost arbitration |
| tx_finish | output | 1 | One-cycle transmit-finish event |

## Verification
Two functions can fall in the same cycle: a software cancel (command write with bit 0 clear) and the engine's acceptance of the offered frame. The bench provokes this by raising `frm_ready` and issuing the cancel write on the same clock edge. It then judges the outcome in three ways. The scoreboard must see the handshake with the expected frame, `stat_in_progress` must be 1 on the following cycle, and the later success must still produce a finish event. A plain cancel without acceptance is run as the contrast case, where no handshake and no finish may appear.

// File: rtl/cantx_pkg.sv
// Package: shared types and register word addresses for the CAN transmit
// message buffer. Assumes a 32-bit register data path.
package cantx_pkg;
    localparam int ID_W     = 29;
    localparam int DLC_W    = 4;
    localparam int NBYTES   = 8;
    localparam int DATA_W   = NBYTES * 8;
    localparam int WORD_W   = 32;

    localparam logic [2:0] ADR_MODE  = 3'd0;
    localparam logic [2:0] ADR_CMD   = 3'd1;
    localparam logic [2:0] ADR_DESC  = 3'd2;
    localparam logic [2:0] ADR_IDENT = 3'd3;
    localparam logic [2:0] ADR_PLO   = 3'd4;
    localparam logic [2:0] ADR_PHI   = 3'd5;

    localparam int BIT_REQ   = 0;
    localparam int BIT_RETX  = 10;
    localparam int BIT_EXT   = 7;
    localparam int BIT_RTR   = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_ACTIVE = 2'd2
    } tx_state_t;

    typedef struct packed {
        logic              ext;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } tx_frame_t;
endpackage

// File: rtl/cantx_regfile.sv
// Module: cantx_regfile
// Holds the mode word and the frame registers written by software.
// Assumes: frame writes are dropped while busy is high; mode writes
// are always accepted. Identifier storage is 29 bits wide, so upper
// bits of an identifier write are discarded.
module cantx_regfile
    import cantx_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              busy,
    output logic              auto_retx,
    output tx_frame_t         frame_raw
);
    localparam int HALF_W = DATA_W / 2;

    logic              ext_q, rtr_q;
    logic [DLC_W-1:0]  dlc_q;
    logic [ID_W-1:0]   id_q;
    logic [HALF_W-1:0] plo_q, phi_q;

    // Register writes: mode always, frame fields only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_retx <= 1'b0;
            ext_q     <= 1'b0;
            rtr_q     <= 1'b0;
            dlc_q     <= '0;
            id_q      <= '0;
            plo_q     <= '0;
            phi_q     <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_MODE))
                auto_retx <= wr_data[BIT_RETX];
            if (!busy) begin
                if (wr_addr == ADDR_W'(ADR_DESC)) begin
                    ext_q <= wr_data[BIT_EXT];
                    rtr_q <= wr_data[BIT_RTR];
                    dlc_q <= wr_data[DLC_W-1:0];
                end
                if (wr_addr == ADDR_W'(ADR_IDENT)) id_q  <= wr_data[ID_W-1:0];
                if (wr_addr == ADDR_W'(ADR_PLO))   plo_q <= wr_data[HALF_W-1:0];
                if (wr_addr == ADDR_W'(ADR_PHI))   phi_q <= wr_data[HALF_W-1:0];
            end
        end
    end

    // Assemble the stored frame.
    always_comb begin
        frame_raw.ext  = ext_q;
        frame_raw.rtr  = rtr_q;
        frame_raw.dlc  = dlc_q;
        frame_raw.id   = id_q;
        frame_raw.data = {phi_q, plo_q};
    end

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(id_q) && $stable(plo_q) && $stable(phi_q) && $stable(dlc_q))); // R7
endmodule

// File: rtl/cantx_frame_fmt.sv
// Module: cantx_frame_fmt
// Shapes the stored frame for the engine: a remote frame is sent with
// zero length code and an all-zero payload. Purely combinational.
module cantx_frame_fmt
    import cantx_pkg::*;
(
    input  tx_frame_t frame_in,
    output tx_frame_t frame_out
);
    // Header fields: length forced to zero for remote frames.
    always_comb begin
        frame_out.ext = frame_in.ext;
        frame_out.rtr = frame_in.rtr;
        frame_out.id  = frame_in.id;
        frame_out.dlc = frame_in.rtr ? '0 : frame_in.dlc;
    end

    // Payload byte lanes: each lane gated off for remote frames.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign frame_out.data[b*8 +: 8] = frame_in.rtr ? 8'h00 : frame_in.data[b*8 +: 8];
    end
endmodule

// File: rtl/cantx_ctrl.sv
// Module: cantx_ctrl
// Request state machine: idle, pending (offered to the engine) and active
// (accepted, being sent). Assumes the engine raises done or arb_lost only
// for a frame it has accepted; such pulses in other states are ignored.
module cantx_ctrl
    import cantx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_req,
    input  logic auto_retx,
    input  logic frm_ready,
    input  logic eng_done,
    input  logic eng_arb_lost,
    output logic busy,
    output logic in_progress,
    output logic frm_valid,
    output logic tx_finish
);
    tx_state_t state_q, state_d;

    // Next-state decision; acceptance takes priority over cancel.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr && cmd_req) state_d = ST_PEND;
            ST_PEND:   if (frm_ready) state_d = ST_ACTIVE;
                       else if (cmd_wr && !cmd_req) state_d = ST_IDLE;
            ST_ACTIVE: if (eng_done) state_d = ST_IDLE;
                       else if (eng_arb_lost) state_d = auto_retx ? ST_PEND : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and registered finish event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tx_finish <= 1'b0;
        end else begin
            state_q   <= state_d;
            tx_finish <= (state_q == ST_ACTIVE) && eng_done;
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign in_progress = (state_q == ST_ACTIVE);
    assign frm_valid   = (state_q == ST_PEND);

    AST_FINISH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_finish |=> !tx_finish); // R9
    AST_FINISH_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_finish |-> ($past(in_progress) && !busy)); // R9
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready && !(cmd_wr && !cmd_req)) |=> frm_valid); // R11
    AST_RETX_REOFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_progress && eng_arb_lost && !eng_done && auto_retx) |=> frm_valid); // R6
    AST_ACCEPT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ready) |=> in_progress); // R8
endmodule

// File: rtl/cantx_msgbuf.sv
// Module: cantx_msgbuf (top)
// Single-frame CAN transmit buffer with a word-addressed write port,
// status outputs and a valid/ready frame interface to a bit-stream engine.
// Assumes a 32-bit write data path and synchronous active-low reset.
module cantx_msgbuf
    import cantx_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              stat_buf_full,
    output logic              stat_in_progress,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic              frm_ext,
    output logic              frm_rtr,
    output logic [3:0]        frm_dlc,
    output logic [28:0]       frm_id,
    output logic [63:0]       frm_data,
    input  logic              eng_done,
    input  logic              eng_arb_lost,
    output logic              tx_finish
);
    logic      busy, auto_retx, cmd_wr;
    tx_frame_t frame_raw, frame_fmt;

    assign cmd_wr = reg_wr_en && (reg_addr == ADDR_W'(ADR_CMD));

    cantx_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .busy      (busy),
        .auto_retx (auto_retx),
        .frame_raw (frame_raw)
    );

    cantx_frame_fmt u_fmt (
        .frame_in  (frame_raw),
        .frame_out (frame_fmt)
    );

    cantx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_req      (reg_wdata[BIT_REQ]),
        .auto_retx    (auto_retx),
        .frm_ready    (frm_ready),
        .eng_done     (eng_done),
        .eng_arb_lost (eng_arb_lost),
        .busy         (busy),
        .in_progress  (stat_in_progress),
        .frm_valid    (frm_valid),
        .tx_finish    (tx_finish)
    );

    assign stat_buf_full = busy;
    assign frm_ext  = frame_fmt.ext;
    assign frm_rtr  = frame_fmt.rtr;
    assign frm_dlc  = frame_fmt.dlc;
    assign frm_id   = frame_fmt.id;
    assign frm_data = frame_fmt.data;

    AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=> (!frm_valid || ($stable(frm_id) && $stable(frm_data)))); // R11
    AST_ACTIVE_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_in_progress) |-> $past(frm_valid && frm_ready)); // R10
endmodule

// File: tb/cantx_msgbuf_tb.sv
// Bench: scoreboard. Driver tasks push expected frames; a monitor pops and
// compares them at each engine handshake. Inputs change 2 ns after a
// rising edge; outputs are sampled at falling edges.
module cantx_msgbuf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        stat_buf_full, stat_in_progress, frm_valid;
    logic        frm_ready = 1'b0;
    logic        frm_ext, frm_rtr;
    logic [3:0]  frm_dlc;
    logic [28:0] frm_id;
    logic [63:0] frm_data;
    logic        eng_done = 1'b0, eng_arb_lost = 1'b0;
    logic        tx_finish;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [98:0] exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    cantx_msgbuf dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .stat_buf_full(stat_buf_full),
        .stat_in_progress(stat_in_progress), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
        .frm_dlc(frm_dlc), .frm_id(frm_id), .frm_data(frm_data),
        .eng_done(eng_done), .eng_arb_lost(eng_arb_lost), .tx_finish(tx_finish)
    );

    task automatic check(input string req, input logic [98:0] act, input logic [98:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frame per R2..R5.
    function automatic logic [98:0] model(input logic [31:0] desc, input logic [31:0] id,
                                         input logic [31:0] lo, input logic [31:0] hi);
        logic rtr = desc[6];
        return {desc[7], rtr, rtr ? 4'd0 : desc[3:0], id[28:0], rtr ? 64'd0 : {hi, lo}};
    endfunction

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        step();
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] desc, input logic [31:0] id,
                        input logic [31:0] lo, input logic [31:0] hi);
        reg_wr(3'd1, 32'h0);
        reg_wr(3'd2, desc);
        reg_wr(3'd3, id);
        reg_wr(3'd4, lo);
        reg_wr(3'd5, hi);
    endtask

    task automatic request(input logic [98:0] exp);
        exp_q.push_back(exp);
        reg_wr(3'd1, 32'h1);
    endtask

    task automatic accept();
        step(); frm_ready = 1'b1;
        step(); frm_ready = 1'b0;
    endtask

    task automatic pulse_done();
        step(); eng_done = 1'b1;
        step(); eng_done = 1'b0;
    endtask

    task automatic pulse_arb();
        step(); eng_arb_lost = 1'b1;
        step(); eng_arb_lost = 1'b0;
    endtask

    // Monitor: compare each handshake against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && frm_valid && frm_ready) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected handshake", 99'd1, 99'd0);
            end else begin
                logic [98:0] e;
                e = exp_q.pop_front();
                check("R2/R3/R4/R5/R7 frame", {frm_ext, frm_rtr, frm_dlc, frm_id, frm_data}, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [98:0] e;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset state", {stat_buf_full, stat_in_progress, frm_valid, tx_finish}, 99'd0);

        // Standard data frame, byte order, finish pulse.
        load(32'h0000_0008, 32'h0000_0123, 32'h4433_2211, 32'h8877_6655);
        request(model(32'h08, 32'h123, 32'h44332211, 32'h88776655));
        @(negedge clk);
        check("R1 request raises full/valid", {stat_buf_full, frm_valid, stat_in_progress}, 99'b110);
        check("R4 byte 0 position", frm_data[7:0], 8'h11);
        accept();
        @(negedge clk);
        check("R10 in progress after accept", {stat_in_progress, frm_valid}, 99'b10);
        reg_wr(3'd1, 32'h0);
        @(negedge clk);
        check("R8 clear after accept no effect", stat_in_progress, 1'b1);
        pulse_done();
        @(negedge clk);
        check("R9 finish pulse and busy clear", {tx_finish, stat_buf_full, stat_in_progress}, 99'b100);
        @(negedge clk);
        check("R9 finish one cycle", tx_finish, 1'b0);

        // Extended id with upper bits set; write during busy ignored.
        load(32'h0000_0084, 32'hFFFF_ABCD, 32'hDEAD_BEEF, 32'h0);
        request(model(32'h84, 32'hFFFF_ABCD, 32'hDEADBEEF, 32'h0));
        @(negedge clk);
        check("R3 identifier low 29 bits", frm_id, 29'h1FFF_ABCD);
        reg_wr(3'd3, 32'h0000_0055);
        reg_wr(3'd4, 32'h1234_5678);
        @(negedge clk);
        check("R7 busy write ignored", frm_id, 29'h1FFF_ABCD);
        accept();
        pulse_done();

        // Remote frame: length and payload forced to zero.
        load(32'h0000_00C5, 32'h0000_0777, 32'hAAAA_AAAA, 32'hBBBB_BBBB);
        request(model(32'hC5, 32'h777, 32'hAAAAAAAA, 32'hBBBBBBBB));
        @(negedge clk);
        check("R5 remote zero length/data", {frm_rtr, frm_dlc, frm_data}, {1'b1, 4'd0, 64'd0});
        accept();
        pulse_done();

        // Cancel before acceptance.
        load(32'h0000_0002, 32'h0000_0011, 32'h1, 32'h2);
        reg_wr(3'd1, 32'h1);
        reg_wr(3'd1, 32'h0);
        @(negedge clk);
        check("R8 cancel returns idle", {stat_buf_full, frm_valid}, 99'b00);
        accept();
        @(negedge clk);
        check("R8 no activity after cancel", {stat_in_progress, tx_finish}, 99'b00);

        // Cancel and acceptance in the same cycle: acceptance wins.
        load(32'h0000_0003, 32'h0000_0022, 32'h0003_0201, 32'h0);
        request(model(32'h03, 32'h22, 32'h00030201, 32'h0));
        step();
        frm_ready = 1'b1; reg_wr_en = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0;
        step();
        frm_ready = 1'b0; reg_wr_en = 1'b0;
        @(negedge clk);
        check("R8 accept wins over cancel", {stat_in_progress, stat_buf_full}, 99'b11);
        pulse_done();
        @(negedge clk);
        check("R9 finish after contested accept", tx_finish, 1'b1);

        // Lost arbitration with retransmission enabled.
        reg_wr(3'd0, 32'h0000_0400);
        load(32'h0000_0001, 32'h0000_0333, 32'h0000_00EE, 32'h0);
        e = model(32'h01, 32'h333, 32'hEE, 32'h0);
        request(e);
        accept();
        exp_q.push_back(e);
        pulse_arb();
        @(negedge clk);
        check("R6 retransmit re-offers", {frm_valid, stat_in_progress, tx_finish}, 99'b100);
        accept();
        pulse_done();
        @(negedge clk);
        check("R6 retransmitted frame finishes", tx_finish, 1'b1);

        // Lost arbitration with retransmission disabled.
        reg_wr(3'd0, 32'h0);
        load(32'h0000_0001, 32'h0000_0444, 32'h5, 32'h0);
        request(model(32'h01, 32'h444, 32'h5, 32'h0));
        accept();
        pulse_arb();
        @(negedge clk);
        check("R6 dropped without retransmit", {frm_valid, stat_buf_full, tx_finish}, 99'b000);
        repeat (2) @(negedge clk);
        check("R6 no finish after drop", tx_finish, 1'b0);

        check("R1 scoreboard drained", exp_q.size(), 99'd0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule